// File: doc/BRIEF.md
# Home-Node Address Resolution Unit

This block sits at one node of a multicore mesh, between the node's caches, its slice of local memory and the network packetizer. The caches do not know where memory lives. They issue plain requests, and this unit reads the upper bits of each address as the number of the node that owns it. A request owned by this node goes to local memory. A request owned by any other node goes out toward the network, tagged with the index of the cache that issued it.

The local memory port is shared by round-robin arbitration. The requesters are the caches and one extra requester that carries requests arriving from remote nodes. That remote requester uses the same handshake as a cache, so the memory sees every request in the same form. Only one memory access is in flight at a time. Each memory response carries the tag of the requester it belongs to, and the unit steers it back to that requester. Network responses carry the cache index and are steered the same way.

A node with no local memory is built by setting the memory size parameter to zero. Every cache request is then forwarded.

Top module: `home_route_unit`

## Requirements
- R1: An address is split at bit LOCAL_W. Bits [ADDR_W-1:LOCAL_W] form the home field. Bits [LOCAL_W-1:0] form the local word address, and only these bits are presented on `mem_addr_o`.
- R2: A cache request whose home field equals `node_id_i` is sent to local memory. Any other cache request leaves on the forward port with its full address, write enable, write data and the cache index on `fwd_src_o`.
- R3: When MEM_WORDS is 0, every cache request is forwarded whatever its home field. In that case `mem_req_valid_o` never rises and `rin_ready_o` stays low.
- R4: Requesters at local memory are numbered 0..N_CACHE-1 for the caches and N_CACHE for the remote-inbound requester. After requester k is served, the search for the next grant starts at k+1, wrapping to 0. After reset the search starts at 0.
- R5: At most one local memory access is in flight. After a request is accepted (`mem_req_valid_o` and `mem_req_ready_i` high), no other request is presented until a `mem_rsp_valid_i` has been received.
- R6: `mem_tag_o` carries the index of the granted requester. A memory response with tag t < N_CACHE raises `c_rsp_valid_o[t]` with `mem_rsp_rdata_i`. Tag N_CACHE raises `rin_rsp_valid_o` instead.
- R7: A forward-port response with source s raises `c_rsp_valid_o[s]` with `fwd_rsp_rdata_i`. No other cache sees it.
- R8: A request is taken when valid and ready are both high in the same cycle, on the request side and on the forward port. Caches competing for the forward port are served in round-robin order.
- R9: During reset all valid and ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | ADDR_W-LOCAL_W | Number of this node |
| c_req_valid_i | input | N_CACHE | Cache request valid, one bit per cache |
| c_req_ready_o | output | N_CACHE | Cache request accepted |
| c_req_addr_i | input | N_CACHE*ADDR_W | Cache request addresses, cache i at slice i |
| c_req_we_i | input | N_CACHE | Cache write enable |
| c_req_wdata_i | input | N_CACHE*DATA_W | Cache write data |
| c_rsp_valid_o | output | N_CACHE | Response valid toward each cache |
| c_rsp_rdata_o | output | N_CACHE*DATA_W | Response data toward each cache |
| rin_valid_i | input | 1 | Remote-inbound request valid |
| rin_ready_o | output | 1 | Remote-inbound request accepted |
| rin_addr_i | input | LOCAL_W | Remote-inbound local word address |
| rin_we_i | input | 1 | Remote-inbound write enable |
| rin_wdata_i | input | DATA_W | Remote-inbound write data |
| rin_rsp_valid_o | output | 1 | Response valid toward the remote requester |
| rin_rsp_rdata_o | output | DATA_W | Response data toward the remote requester |
| mem_req_valid_o | output | 1 | Local memory request valid |
| mem_req_ready_i | input | 1 | Local memory accepts request |
| mem_addr_o | output | LOCAL_W | Local memory word address |
| mem_we_o | output | 1 | Local memory write enable |
| mem_wdata_o | output | DATA_W | Local memory write data |
| mem_tag_o | output | TAG_W | Requester index of the presented request |
| mem_rsp_valid_i | input | 1 | Local memory response valid |
| mem_rsp_tag_i | input | TAG_W | Tag returned with the response |
| mem_rsp_rdata_i | input | DATA_W | Local memory response data |
| fwd_valid_o | output | 1 | Forwarded request valid |
| fwd_ready_i | input | 1 | Packetizer accepts forwarded request |
| fwd_addr_o | output | ADDR_W | Forwarded full address |
| fwd_we_o | output | 1 | Forwarded write enable |
| fwd_wdata_o | output | DATA_W | Forwarded write data |
| fwd_src_o | output | SRC_W | Index of the cache that issued it |
| fwd_rsp_valid_i | input | 1 | Response from the network valid |
| fwd_rsp_src_i | input | SRC_W | Cache index the response belongs to |
| fwd_rsp_rdata_i | input | DATA_W | Response data from the network |

## Verification
A directed burst first serves cache 0 alone. It then raises all three local requesters in the same cycle and expects the memory to take them in the order 1, 2, 0. This order separates a rotating pointer from fixed priority, and also from a pointer that fails to advance. Random traffic then mixes home and foreign addresses, reads and writes, and stalls on both the memory port and the forward port. Each accepted request is checked against the destination its home field calls for, and each response against the requester that issued it. Overlapping responses from memory and network to different caches show whether steering uses the tag or mixes up requesters. A second instance built without local memory receives an address whose home field names this node; forwarding that request shows the size-zero variant.

// File: rtl/hru_pkg.sv
package hru_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hru_rr_arb.sv
module hru_rr_arb #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  input  logic [IW-1:0] adv_idx_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    logic found;
    int   j;
    found     = 1'b0;
    gnt_o     = '0;
    gnt_idx_o = '0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr_q) + k) % N;
      if (!found && req_i[j]) begin
        found     = 1'b1;
        gnt_o[j]  = 1'b1;
        gnt_idx_o = IW'(j);
      end
    end
  end

  // search restarts one past the requester that was just served
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (adv_idx_i >= IW'(N - 1)) ? '0 : adv_idx_i + 1'b1;
  end

  p_gnt_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_if_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_o != '0));
endmodule

// File: rtl/hru_home_decode.sv
module hru_home_decode #(
  parameter int ADDR_W    = 16,
  parameter int LOCAL_W   = 10,
  parameter int MEM_WORDS = 1024
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [ADDR_W-LOCAL_W-1:0] node_id_i,
  output logic                      is_local_o
);
  if (MEM_WORDS == 0) begin : g_nomem
    assign is_local_o = 1'b0;
  end else begin : g_mem
    assign is_local_o = (addr_i[ADDR_W-1:LOCAL_W] == node_id_i);
  end
endmodule

// File: rtl/home_route_unit.sv
module home_route_unit #(
  parameter  int N_CACHE   = 2,
  parameter  int ADDR_W    = 16,
  parameter  int LOCAL_W   = 10,
  parameter  int DATA_W    = 32,
  parameter  int MEM_WORDS = 1024,
  localparam int HOME_W    = ADDR_W - LOCAL_W,
  localparam int REQ_N     = N_CACHE + 1,
  localparam int TAG_W     = hru_pkg::idx_w(REQ_N),
  localparam int SRC_W     = hru_pkg::idx_w(N_CACHE)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [HOME_W-1:0]         node_id_i,
  input  logic [N_CACHE-1:0]        c_req_valid_i,
  output logic [N_CACHE-1:0]        c_req_ready_o,
  input  logic [N_CACHE*ADDR_W-1:0] c_req_addr_i,
  input  logic [N_CACHE-1:0]        c_req_we_i,
  input  logic [N_CACHE*DATA_W-1:0] c_req_wdata_i,
  output logic [N_CACHE-1:0]        c_rsp_valid_o,
  output logic [N_CACHE*DATA_W-1:0] c_rsp_rdata_o,
  input  logic                      rin_valid_i,
  output logic                      rin_ready_o,
  input  logic [LOCAL_W-1:0]        rin_addr_i,
  input  logic                      rin_we_i,
  input  logic [DATA_W-1:0]         rin_wdata_i,
  output logic                      rin_rsp_valid_o,
  output logic [DATA_W-1:0]         rin_rsp_rdata_o,
  output logic                      mem_req_valid_o,
  input  logic                      mem_req_ready_i,
  output logic [LOCAL_W-1:0]        mem_addr_o,
  output logic                      mem_we_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  output logic [TAG_W-1:0]          mem_tag_o,
  input  logic                      mem_rsp_valid_i,
  input  logic [TAG_W-1:0]          mem_rsp_tag_i,
  input  logic [DATA_W-1:0]         mem_rsp_rdata_i,
  output logic                      fwd_valid_o,
  input  logic                      fwd_ready_i,
  output logic [ADDR_W-1:0]         fwd_addr_o,
  output logic                      fwd_we_o,
  output logic [DATA_W-1:0]         fwd_wdata_o,
  output logic [SRC_W-1:0]          fwd_src_o,
  input  logic                      fwd_rsp_valid_i,
  input  logic [SRC_W-1:0]          fwd_rsp_src_i,
  input  logic [DATA_W-1:0]         fwd_rsp_rdata_i
);
  localparam bit HAS_MEM = (MEM_WORDS != 0);

  logic [N_CACHE-1:0] is_loc, fwd_cand, fwd_gnt;
  logic [REQ_N-1:0]   mem_cand, mem_gnt;
  logic [TAG_W-1:0]   mem_gidx, cur_tag_q;
  logic [SRC_W-1:0]   fwd_gidx;
  logic               busy_q, mem_done, fwd_take;

  for (genvar i = 0; i < N_CACHE; i++) begin : g_dec
    hru_home_decode #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W), .MEM_WORDS(MEM_WORDS)) u_dec (
      .addr_i    (c_req_addr_i[i*ADDR_W +: ADDR_W]),
      .node_id_i (node_id_i),
      .is_local_o(is_loc[i])
    );
  end

  // remote-inbound traffic is the last requester at local memory
  assign mem_cand = {rin_valid_i & HAS_MEM, c_req_valid_i & is_loc} & {REQ_N{~busy_q}};
  assign fwd_cand = c_req_valid_i & ~is_loc;
  assign mem_done = busy_q & mem_rsp_valid_i;
  assign fwd_take = fwd_valid_o & fwd_ready_i;

  hru_rr_arb #(.N(REQ_N), .IW(TAG_W)) u_mem_arb (
    .clk_i, .rst_ni,
    .req_i(mem_cand), .adv_i(mem_done), .adv_idx_i(cur_tag_q),
    .gnt_o(mem_gnt), .gnt_idx_o(mem_gidx)
  );

  hru_rr_arb #(.N(N_CACHE), .IW(SRC_W)) u_fwd_arb (
    .clk_i, .rst_ni,
    .req_i(fwd_cand), .adv_i(fwd_take), .adv_idx_i(fwd_gidx),
    .gnt_o(fwd_gnt), .gnt_idx_o(fwd_gidx)
  );

  always_comb begin
    mem_addr_o  = '0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    fwd_addr_o  = '0;
    fwd_we_o    = 1'b0;
    fwd_wdata_o = '0;
    for (int i = 0; i < N_CACHE; i++) begin
      if (mem_gnt[i]) begin
        mem_addr_o  = c_req_addr_i[i*ADDR_W +: LOCAL_W];
        mem_we_o    = c_req_we_i[i];
        mem_wdata_o = c_req_wdata_i[i*DATA_W +: DATA_W];
      end
      if (fwd_gnt[i]) begin
        fwd_addr_o  = c_req_addr_i[i*ADDR_W +: ADDR_W];
        fwd_we_o    = c_req_we_i[i];
        fwd_wdata_o = c_req_wdata_i[i*DATA_W +: DATA_W];
      end
    end
    if (mem_gnt[N_CACHE]) begin
      mem_addr_o  = rin_addr_i;
      mem_we_o    = rin_we_i;
      mem_wdata_o = rin_wdata_i;
    end
  end

  assign mem_req_valid_o = |mem_gnt;
  assign mem_tag_o       = mem_gidx;
  assign fwd_valid_o     = |fwd_gnt;
  assign fwd_src_o       = fwd_gidx;
  assign c_req_ready_o   = (mem_gnt[N_CACHE-1:0] & {N_CACHE{mem_req_ready_i}})
                         | (fwd_gnt & {N_CACHE{fwd_ready_i}});
  assign rin_ready_o     = mem_gnt[N_CACHE] & mem_req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cur_tag_q <= '0;
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      busy_q    <= 1'b1;
      cur_tag_q <= mem_gidx;
    end else if (mem_done) begin
      busy_q    <= 1'b0;
    end
  end

  // one outstanding per requester, so memory and network never target the same cache together
  always_comb begin
    for (int i = 0; i < N_CACHE; i++) begin
      c_rsp_valid_o[i] = (mem_done && mem_rsp_tag_i == TAG_W'(i))
                       | (fwd_rsp_valid_i && fwd_rsp_src_i == SRC_W'(i));
      c_rsp_rdata_o[i*DATA_W +: DATA_W] = (mem_done && mem_rsp_tag_i == TAG_W'(i))
                                        ? mem_rsp_rdata_i : fwd_rsp_rdata_i;
    end
  end

  assign rin_rsp_valid_o = mem_done && (mem_rsp_tag_i == TAG_W'(N_CACHE));
  assign rin_rsp_rdata_o = mem_rsp_rdata_i;

  p_single_access_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !mem_req_valid_o);
  p_mem_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o);
  p_fwd_foreign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (!HAS_MEM || fwd_addr_o[ADDR_W-1:LOCAL_W] != node_id_i));
  p_fwd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o && !fwd_ready_i |=> fwd_valid_o);
  p_rin_only_mem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rin_ready_o |-> mem_req_valid_o);
endmodule

// File: tb/home_route_unit_test.sv
module home_route_unit_test;
  localparam int T       = 10;
  localparam int N_CACHE = 2;
  localparam int ADDR_W  = 16;
  localparam int LOCAL_W = 10;
  localparam int DATA_W  = 32;
  localparam int HOME_W  = ADDR_W - LOCAL_W;
  localparam int REQ_N   = N_CACHE + 1;
  localparam int TAG_W   = 2;
  localparam int SRC_W   = 1;
  localparam logic [HOME_W-1:0] NODE = 6'd5;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #(T/2) clk = ~clk;

  logic [N_CACHE-1:0] c_req_valid, c_req_ready, c_req_we, c_rsp_valid;
  logic [N_CACHE*ADDR_W-1:0] c_req_addr;
  logic [N_CACHE*DATA_W-1:0] c_req_wdata, c_rsp_rdata;
  logic rin_valid, rin_ready, rin_we, rin_rsp_valid;
  logic [LOCAL_W-1:0] rin_addr;
  logic [DATA_W-1:0] rin_wdata, rin_rsp_rdata;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_we, mem_rsp_valid = 1'b0;
  logic [LOCAL_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rsp_rdata = '0;
  logic [TAG_W-1:0] mem_tag, mem_rsp_tag = '0;
  logic fwd_valid, fwd_ready = 1'b1, fwd_we, fwd_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] fwd_addr;
  logic [DATA_W-1:0] fwd_wdata, fwd_rsp_rdata = '0;
  logic [SRC_W-1:0] fwd_src, fwd_rsp_src = '0;

  logic              dv  [REQ_N];
  logic [ADDR_W-1:0] da  [REQ_N];
  logic              dwe [REQ_N];
  logic [DATA_W-1:0] dwd [REQ_N];

  always_comb begin
    for (int i = 0; i < N_CACHE; i++) begin
      c_req_valid[i] = dv[i];
      c_req_we[i]    = dwe[i];
      c_req_addr[i*ADDR_W +: ADDR_W]  = da[i];
      c_req_wdata[i*DATA_W +: DATA_W] = dwd[i];
    end
    rin_valid = dv[N_CACHE];
    rin_addr  = da[N_CACHE][LOCAL_W-1:0];
    rin_we    = dwe[N_CACHE];
    rin_wdata = dwd[N_CACHE];
  end

  home_route_unit #(.N_CACHE(N_CACHE), .ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W),
                    .DATA_W(DATA_W), .MEM_WORDS(1024)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(NODE),
    .c_req_valid_i(c_req_valid), .c_req_ready_o(c_req_ready), .c_req_addr_i(c_req_addr),
    .c_req_we_i(c_req_we), .c_req_wdata_i(c_req_wdata),
    .c_rsp_valid_o(c_rsp_valid), .c_rsp_rdata_o(c_rsp_rdata),
    .rin_valid_i(rin_valid), .rin_ready_o(rin_ready), .rin_addr_i(rin_addr),
    .rin_we_i(rin_we), .rin_wdata_i(rin_wdata),
    .rin_rsp_valid_o(rin_rsp_valid), .rin_rsp_rdata_o(rin_rsp_rdata),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_tag_o(mem_tag),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_tag_i(mem_rsp_tag), .mem_rsp_rdata_i(mem_rsp_rdata),
    .fwd_valid_o(fwd_valid), .fwd_ready_i(fwd_ready), .fwd_addr_o(fwd_addr),
    .fwd_we_o(fwd_we), .fwd_wdata_o(fwd_wdata), .fwd_src_o(fwd_src),
    .fwd_rsp_valid_i(fwd_rsp_valid), .fwd_rsp_src_i(fwd_rsp_src), .fwd_rsp_rdata_i(fwd_rsp_rdata)
  );

  // instance without local memory
  logic [N_CACHE-1:0] nm_cv = '0, nm_cready, nm_crsp;
  logic [N_CACHE*ADDR_W-1:0] nm_caddr = '0;
  logic [N_CACHE*DATA_W-1:0] nm_crdata;
  logic nm_rin_valid = 1'b0, nm_rin_ready, nm_rin_rsp, nm_mem_valid, nm_mem_we;
  logic nm_fwd_valid, nm_fwd_we;
  logic [DATA_W-1:0] nm_rin_rdata, nm_mem_wdata, nm_fwd_wdata;
  logic [LOCAL_W-1:0] nm_mem_addr;
  logic [TAG_W-1:0] nm_mem_tag;
  logic [ADDR_W-1:0] nm_fwd_addr;
  logic [SRC_W-1:0] nm_fwd_src;

  home_route_unit #(.N_CACHE(N_CACHE), .ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W),
                    .DATA_W(DATA_W), .MEM_WORDS(0)) uut_nm (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(NODE),
    .c_req_valid_i(nm_cv), .c_req_ready_o(nm_cready), .c_req_addr_i(nm_caddr),
    .c_req_we_i('0), .c_req_wdata_i('0),
    .c_rsp_valid_o(nm_crsp), .c_rsp_rdata_o(nm_crdata),
    .rin_valid_i(nm_rin_valid), .rin_ready_o(nm_rin_ready), .rin_addr_i('0),
    .rin_we_i(1'b0), .rin_wdata_i('0),
    .rin_rsp_valid_o(nm_rin_rsp), .rin_rsp_rdata_o(nm_rin_rdata),
    .mem_req_valid_o(nm_mem_valid), .mem_req_ready_i(1'b1), .mem_addr_o(nm_mem_addr),
    .mem_we_o(nm_mem_we), .mem_wdata_o(nm_mem_wdata), .mem_tag_o(nm_mem_tag),
    .mem_rsp_valid_i(1'b0), .mem_rsp_tag_i('0), .mem_rsp_rdata_i('0),
    .fwd_valid_o(nm_fwd_valid), .fwd_ready_i(1'b1), .fwd_addr_o(nm_fwd_addr),
    .fwd_we_o(nm_fwd_we), .fwd_wdata_o(nm_fwd_wdata), .fwd_src_o(nm_fwd_src),
    .fwd_rsp_valid_i(1'b0), .fwd_rsp_src_i('0), .fwd_rsp_rdata_i('0)
  );

  int n_chk = 0, n_fail = 0;
  int rsp_cnt [REQ_N];
  bit rand_mode = 1'b0, rec_en = 1'b0;
  int order_q [$];
  logic [DATA_W-1:0] exp_q [REQ_N][$];
  bit                exp_loc  [REQ_N];
  logic [ADDR_W-1:0] exp_addr [REQ_N];
  logic              exp_we   [REQ_N];
  logic [DATA_W-1:0] exp_wd   [REQ_N];
  logic [DATA_W-1:0] bmem   [1 << LOCAL_W];
  logic [DATA_W-1:0] shadow [1 << LOCAL_W];

  function automatic logic [DATA_W-1:0] init_word(input int a);
    return {16'h5A00 | 16'(a), ~16'(a)};
  endfunction
  function automatic logic [DATA_W-1:0] net_word(input logic [ADDR_W-1:0] a);
    return {~a, a ^ 16'h0F0F};
  endfunction
  function automatic logic rdy(input int i);
    return (i < N_CACHE) ? c_req_ready[i] : rin_ready;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard driver: one outstanding request per requester
  task automatic do_req(input int i, input logic [ADDR_W-1:0] a, input logic we,
                        input logic [DATA_W-1:0] wd);
    logic [LOCAL_W-1:0] la;
    bit loc;
    int n0;
    la  = a[LOCAL_W-1:0];
    loc = (i == N_CACHE) || (a[ADDR_W-1:LOCAL_W] == NODE);
    n0  = rsp_cnt[i];
    @(negedge clk);
    exp_loc[i] = loc; exp_addr[i] = a; exp_we[i] = we; exp_wd[i] = wd;
    if (loc) begin
      exp_q[i].push_back(we ? '0 : shadow[la]);
      if (we) shadow[la] = wd;
    end else begin
      exp_q[i].push_back(we ? '0 : net_word(a));
    end
    dv[i] = 1'b1; da[i] = a; dwe[i] = we; dwd[i] = wd;
    while (1) begin
      #(T/4);
      if (rdy(i)) break;
      @(negedge clk);
    end
    @(negedge clk);
    dv[i] = 1'b0;
    wait (rsp_cnt[i] > n0);
  endtask

  task automatic rand_stream(input int i);
    for (int k = 0; k < 30; k++) begin
      int unsigned r;
      logic [HOME_W-1:0] home;
      r    = $urandom;
      home = (r[0] || i == N_CACHE) ? NODE : NODE ^ HOME_W'(1 + (r[7:2] % 63));
      do_req(i, {home, r[15:8], 2'(i)}, r[16], $urandom);
      repeat (r[18:17]) @(negedge clk);
    end
  endtask

  // memory model, network model and monitor in one ordered process
  bit mp = 1'b0;
  int mcnt = 0;
  logic [TAG_W-1:0] mtag;
  logic [DATA_W-1:0] mdata;
  bit np [N_CACHE];
  int ncnt [N_CACHE];
  logic [DATA_W-1:0] ndata [N_CACHE];

  initial begin
    for (int a = 0; a < (1 << LOCAL_W); a++) begin
      bmem[a] = init_word(a);
      shadow[a] = init_word(a);
    end
    for (int i = 0; i < REQ_N; i++) begin
      dv[i] = 1'b0; da[i] = '0; dwe[i] = 1'b0; dwd[i] = '0; rsp_cnt[i] = 0;
    end
    for (int s = 0; s < N_CACHE; s++) begin np[s] = 1'b0; ncnt[s] = 0; end
    forever begin
      bit sent;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mp) begin
        if (mcnt == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_tag = mtag; mem_rsp_rdata = mdata; mp = 1'b0;
        end else mcnt--;
      end
      mem_req_ready = rand_mode ? 1'($urandom % 2) : 1'b1;
      fwd_rsp_valid = 1'b0;
      sent = 1'b0;
      for (int s = 0; s < N_CACHE; s++) begin
        if (np[s]) begin
          if (ncnt[s] == 0 && !sent) begin
            fwd_rsp_valid = 1'b1; fwd_rsp_src = SRC_W'(s); fwd_rsp_rdata = ndata[s];
            np[s] = 1'b0; sent = 1'b1;
          end else if (ncnt[s] > 0) ncnt[s]--;
        end
      end
      fwd_ready = rand_mode ? 1'($urandom % 2) : 1'b1;
      #(T/4);
      // R6 R7: responses reach the requester that issued them
      for (int i = 0; i < N_CACHE; i++) begin
        if (c_rsp_valid[i]) begin
          if (exp_q[i].size() == 0) chk(0, "R6/R7", $sformatf("spurious rsp cache %0d", i), 1, 0);
          else begin
            logic [DATA_W-1:0] e;
            e = exp_q[i].pop_front();
            chk(c_rsp_rdata[i*DATA_W +: DATA_W] == e, "R6/R7",
                $sformatf("rdata cache %0d", i), c_rsp_rdata[i*DATA_W +: DATA_W], e);
          end
          rsp_cnt[i]++;
        end
      end
      if (rin_rsp_valid) begin
        if (exp_q[N_CACHE].size() == 0) chk(0, "R6", "spurious remote rsp", 1, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q[N_CACHE].pop_front();
          chk(rin_rsp_rdata == e, "R6", "remote rdata", rin_rsp_rdata, e);
        end
        rsp_cnt[N_CACHE]++;
      end
      // R1 R2 R5: local memory acceptance
      if (mem_req_valid && mem_req_ready) begin
        int t;
        t = int'(mem_tag);
        chk(!mp && !mem_rsp_valid, "R5", "accept while access in flight", 1, 0);
        if (t > N_CACHE) chk(0, "R6", "tag out of range", t, N_CACHE);
        else begin
          chk(exp_loc[t] && dv[t], "R2", $sformatf("local dest requester %0d", t), 0, 1);
          chk(mem_addr == exp_addr[t][LOCAL_W-1:0], "R1", "local word address",
              mem_addr, exp_addr[t][LOCAL_W-1:0]);
          chk(mem_we == exp_we[t] && (!mem_we || mem_wdata == exp_wd[t]), "R2",
              "mem write fields", {mem_we, mem_wdata}, {exp_we[t], exp_wd[t]});
        end
        mtag = mem_tag;
        mcnt = 1;
        mp   = 1'b1;
        if (mem_we) begin bmem[mem_addr] = mem_wdata; mdata = '0; end
        else mdata = bmem[mem_addr];
        if (rec_en) order_q.push_back(t);
      end
      // R2 R8: forward port acceptance
      if (fwd_valid && fwd_ready) begin
        int s;
        s = int'(fwd_src);
        chk(!np[s], "R8", "second outstanding forward", 1, 0);
        chk(!exp_loc[s] && dv[s], "R2", $sformatf("forward dest cache %0d", s), 0, 1);
        chk(fwd_addr == exp_addr[s] && fwd_we == exp_we[s], "R8", "forward fields",
            {fwd_we, fwd_addr}, {exp_we[s], exp_addr[s]});
        np[s] = 1'b1;
        ncnt[s] = $urandom % 3;
        ndata[s] = fwd_we ? '0 : net_word(fwd_addr);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #(T/4);
    chk(mem_req_valid == 0 && fwd_valid == 0 && rin_ready == 0 && c_req_ready == 0
        && c_rsp_valid == 0 && rin_rsp_valid == 0, "R9", "outputs in reset", 1, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R4: serve 0 alone, then all three together -> 1, 2, 0
    do_req(0, {NODE, 10'h010}, 1'b0, '0);
    rec_en = 1'b1;
    fork
      do_req(0, {NODE, 10'h014}, 1'b0, '0);
      do_req(1, {NODE, 10'h011}, 1'b0, '0);
      do_req(2, {NODE, 10'h012}, 1'b0, '0);
    join
    rec_en = 1'b0;
    chk(order_q.size() == 3, "R4", "grant count", order_q.size(), 3);
    if (order_q.size() == 3) begin
      chk(order_q[0] == 1, "R4", "first grant", order_q[0], 1);
      chk(order_q[1] == 2, "R4", "second grant", order_q[1], 2);
      chk(order_q[2] == 0, "R4", "third grant", order_q[2], 0);
    end

    // R2 R7: foreign read and write, then local write/read back
    do_req(1, {NODE ^ 6'h01, 10'h101}, 1'b0, '0);
    do_req(0, {NODE ^ 6'h20, 10'h200}, 1'b1, 32'hCAFE_0001);
    do_req(0, {NODE, 10'h030}, 1'b1, 32'h1234_5678);
    do_req(0, {NODE, 10'h030}, 1'b0, '0);

    // R3: no local memory -> own-home address still forwarded
    @(negedge clk);
    nm_cv = 2'b01;
    nm_caddr[ADDR_W-1:0] = {NODE, 10'h020};
    nm_rin_valid = 1'b1;
    #(T/4);
    chk(nm_fwd_valid == 1'b1 && nm_fwd_addr == {NODE, 10'h020}, "R3", "forward without memory",
        {nm_fwd_valid, nm_fwd_addr}, {1'b1, NODE, 10'h020});
    chk(nm_mem_valid == 1'b0 && nm_rin_ready == 1'b0, "R3", "memory port idle",
        {nm_mem_valid, nm_rin_ready}, 0);
    chk(nm_cready[0] == 1'b1, "R3", "cache ready via forward", nm_cready[0], 1);
    @(negedge clk);
    nm_cv = '0;
    nm_rin_valid = 1'b0;

    // random traffic with stalls on both ports
    rand_mode = 1'b1;
    fork
      rand_stream(0);
      rand_stream(1);
      rand_stream(2);
    join
    rand_mode = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < REQ_N; i++)
      chk(exp_q[i].size() == 0, "R6", $sformatf("leftover rsp requester %0d", i), exp_q[i].size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule